// File: doc/BRIEF.md
# Scanline Transfer Trigger Controller

This block decides, once for every scanline, whether the horizontal-blank transfer engine has work to start. It keeps an eight-bit channel-enable register that software writes over a simple register bus, and it tracks a completed flag for each channel. When the horizontal dot counter reaches a fixed trigger position, the block raises a pending request in run mode, provided at least one channel is enabled and not yet completed. At the first line of a frame it raises a setup-mode request instead. The enable bits used for the line decision are captured a few clocks before the trigger position. A register write that lands in that short window therefore takes effect on the following line.

The CPU side presents an edge strobe ahead of each bus write. If a request is pending on that strobe, the block clears the request and emits a one-cycle service record. The record carries the mode and two alignment stall lengths. One stall is placed before the transfer window and the other after it, so that the transfer lines up with the CPU clock phase. Both stalls are zero when general-purpose DMA is already running. The actual byte moves, table fetches and address generation belong to other blocks.

Top module: `line_xfer_trigger`

## Requirements
- R1: A write with `wr_en` high to address 0x420C loads `wr_data`, and bit n enables channel n. A write to any other address leaves the enables unchanged.
- R2: `ch_active[n]` is high exactly when channel n is enabled and its completed flag is clear. A pulse on `done_set[n]` sets that flag, and the flag clears when a new scanline starts (any change of `v_count`).
- R3: The line trigger fires on the first cycle of a line in which `h_count >= 1104`. It fires at most once per line.
- R4: When the trigger fires and some channel is enabled (by the captured enables) and not completed, `pending` goes high one cycle later and `mode` reads 1 (run).
- R5: When the trigger fires with no active channel, `pending` stays low and no service record is produced.
- R6: The enable bits used by the trigger are captured when `h_count` first reaches 1104 minus SAMPLE_LEAD (default 4, so 1100). A write after that point does not start a request on the current line, but it does on the next line.
- R7: When `v_count` changes to 0 and any enable bit is set, `pending` goes high with `mode` = 0 (setup).
- R8: A `bus_edge` pulse while `pending` is high clears `pending` on the next cycle. It also raises `svc_valid` for exactly one cycle, with `svc_mode` equal to the mode of the request.
- R9: A free-running clock counter starts at 0 after reset and advances by one every clock, modulo 8. With `gdma_busy` low, `stall_pre` = 8 minus the counter value at the servicing edge, which gives a range of 1 to 8.
- R10: With `gdma_busy` low, `stall_post` = `acc_len` - (`stall_pre` mod `acc_len`). It is 0 when `acc_len` is 0.
- R11: With `gdma_busy` high at the servicing edge, both `stall_pre` and `stall_post` are 0.
- R12: Reset clears the enables, the pending, triggered and mode state, the completed flags and the clock counter. All outputs read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| h_count | input | 11 | Horizontal dot-clock counter |
| v_count | input | 9 | Vertical line counter; any change marks a new line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| done_set | input | 8 | Per-channel completed pulses |
| gdma_busy | input | 1 | General-purpose DMA is running |
| acc_len | input | 4 | Current CPU access length in clocks |
| bus_edge | input | 1 | Strobe ahead of each CPU bus write |
| pending | output | 1 | Transfer request outstanding |
| mode | output | 1 | Request mode: 0 setup, 1 run |
| svc_valid | output | 1 | One-cycle service record strobe |
| svc_mode | output | 1 | Mode of the serviced request |
| stall_pre | output | 4 | Alignment stall before the transfer window |
| stall_post | output | 4 | Alignment stall after the transfer window |
| ch_active | output | 8 | Per-channel enabled and not completed |

## Verification
A wrong capture of the enable bits shows up on the very line where a write lands between position 1100 and 1104. In that case `pending` rises one cycle after the trigger when it should stay low. A triggered flag that fails to latch brings `pending` back after the first service on the same line. A missing clear at the line start makes the next line stay silent. Both faults are visible within a few cycles of the trigger. An error in the clock counter or in the modulo arithmetic appears in the stall fields of the very next service record. The scoreboard compares every such record.

// File: rtl/lxt_pkg.sv
package lxt_pkg;
   typedef enum logic {
      MODE_SETUP = 1'b0,
      MODE_RUN   = 1'b1
   } xfer_mode_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/lxt_enable_reg.sv
module lxt_enable_reg #(
   parameter int unsigned N_CH        = 8,
   parameter int unsigned AW          = 16,
   parameter logic [15:0] ENABLE_ADDR = 16'h420C
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [N_CH-1:0] wr_data,
   input  logic [N_CH-1:0] done_set,
   input  logic            line_start,
   output logic [N_CH-1:0] en_q,
   output logic [N_CH-1:0] completed_q,
   output logic [N_CH-1:0] ch_active
);
   localparam logic [AW-1:0] ADDR_HIT = AW'(ENABLE_ADDR);

   logic wr_hit;
   assign wr_hit = wr_en && (wr_addr == ADDR_HIT);

   always_ff @(posedge clk) begin
      if (rst)         en_q <= '0;
      else if (wr_hit) en_q <= wr_data;
   end

   for (genvar n = 0; n < N_CH; n++) begin : g_chan
      always_ff @(posedge clk) begin
         if (rst)             completed_q[n] <= 1'b0;
         else if (line_start) completed_q[n] <= done_set[n];
         else if (done_set[n]) completed_q[n] <= 1'b1;
      end
      assign ch_active[n] = en_q[n] & ~completed_q[n];
   end

   assert_enable_load_R1: assert property (@(posedge clk) disable iff (rst)
      wr_hit |=> (en_q == $past(wr_data)));

   assert_enable_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !wr_hit |=> $stable(en_q));

   assert_done_masks_R2: assert property (@(posedge clk) disable iff (rst)
      (done_set != '0) |=> ((ch_active & $past(done_set)) == '0));
endmodule

// File: rtl/lxt_line_trigger.sv
module lxt_line_trigger
   import lxt_pkg::*;
#(
   parameter int unsigned N_CH        = 8,
   parameter int unsigned HW          = 11,
   parameter int unsigned VW          = 9,
   parameter int unsigned TRIG_POS    = 1104,
   parameter int unsigned SAMPLE_LEAD = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [HW-1:0]   h_count,
   input  logic [VW-1:0]   v_count,
   input  logic [N_CH-1:0] en_q,
   input  logic [N_CH-1:0] completed_q,
   input  logic            bus_edge,
   output logic            line_start,
   output logic            pending,
   output logic            mode
);
   localparam logic [HW-1:0] TRIG_H = HW'(TRIG_POS);
   localparam logic [HW-1:0] SAMP_H = HW'(TRIG_POS - SAMPLE_LEAD);

   logic [VW-1:0]   v_prev_q;
   logic            triggered_q;
   logic            pending_q;
   xfer_mode_e      mode_q;
   logic [N_CH-1:0] eff_en;
   logic [N_CH-1:0] act_trig;
   logic            trig_hit;
   logic            setup_hit;

   always_ff @(posedge clk) begin
      if (rst) v_prev_q <= '0;
      else     v_prev_q <= v_count;
   end
   assign line_start = (v_count != v_prev_q);

   if (SAMPLE_LEAD == 0) begin : g_live
      assign eff_en = en_q;
   end else begin : g_snap
      logic            sampled_q;
      logic [N_CH-1:0] snap_q;
      logic            sample_hit;
      assign sample_hit = !sampled_q && (h_count >= SAMP_H);
      assign eff_en     = sample_hit ? en_q : snap_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            sampled_q <= 1'b0;
            snap_q    <= '0;
         end else if (line_start) begin
            sampled_q <= 1'b0;
         end else if (sample_hit) begin
            sampled_q <= 1'b1;
            snap_q    <= en_q;
         end
      end
   end

   assign act_trig  = eff_en & ~completed_q;
   assign trig_hit  = !line_start && !triggered_q && (h_count >= TRIG_H);
   assign setup_hit = line_start && (v_count == '0) && (en_q != '0);

   always_ff @(posedge clk) begin
      if (rst)             triggered_q <= 1'b0;
      else if (line_start) triggered_q <= 1'b0;
      else if (trig_hit)   triggered_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
         mode_q    <= MODE_SETUP;
      end else if (setup_hit) begin
         pending_q <= 1'b1;
         mode_q    <= MODE_SETUP;
      end else if (trig_hit && (act_trig != '0)) begin
         pending_q <= 1'b1;
         mode_q    <= MODE_RUN;
      end else if (bus_edge && pending_q) begin
         pending_q <= 1'b0;
      end
   end

   assign pending = pending_q;
   assign mode    = mode_q;

   assert_trigger_latched_R3: assert property (@(posedge clk) disable iff (rst)
      (triggered_q && !line_start) |=> triggered_q);

   assert_run_request_R4: assert property (@(posedge clk) disable iff (rst)
      (trig_hit && (act_trig != '0)) |=> (pending && mode));

   assert_idle_line_R5: assert property (@(posedge clk) disable iff (rst)
      (!line_start && (h_count >= TRIG_H) && (act_trig == '0) && !pending_q) |=> !pending);

   assert_setup_request_R7: assert property (@(posedge clk) disable iff (rst)
      setup_hit |=> (pending && !mode));

   assert_service_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (bus_edge && pending && !line_start && !trig_hit) |=> !pending);
endmodule

// File: rtl/lxt_align.sv
module lxt_align
   import lxt_pkg::*;
#(
   parameter int unsigned CNT_MOD = 8,
   parameter int unsigned ALEN_W  = 4,
   parameter int unsigned CW      = $clog2(CNT_MOD),
   parameter int unsigned SW      = CW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_edge,
   input  logic              pending,
   input  logic              mode,
   input  logic              gdma_busy,
   input  logic [ALEN_W-1:0] acc_len,
   output logic              svc_valid,
   output logic              svc_mode,
   output logic [SW-1:0]     stall_pre,
   output logic [ALEN_W-1:0] stall_post
);
   localparam int unsigned MW = max_u(SW, ALEN_W);

   logic [CW-1:0]     cnt_q;
   logic [SW-1:0]     pre_c;
   logic [MW-1:0]     pre_ext;
   logic [MW-1:0]     alen_ext;
   logic [MW-1:0]     rem_c;
   logic [MW-1:0]     post_full;
   logic [ALEN_W-1:0] post_c;
   logic              svc_hit;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign pre_c     = gdma_busy ? '0 : (SW'(CNT_MOD) - SW'(cnt_q));
   assign pre_ext   = MW'(pre_c);
   assign alen_ext  = MW'(acc_len);
   assign rem_c     = (alen_ext == '0) ? '0 : (pre_ext % alen_ext);
   assign post_full = alen_ext - rem_c;
   assign post_c    = (gdma_busy || (acc_len == '0)) ? '0 : ALEN_W'(post_full);
   assign svc_hit   = bus_edge && pending;

   always_ff @(posedge clk) begin
      if (rst) begin
         svc_valid  <= 1'b0;
         svc_mode   <= MODE_SETUP;
         stall_pre  <= '0;
         stall_post <= '0;
      end else begin
         svc_valid <= svc_hit;
         if (svc_hit) begin
            svc_mode   <= mode;
            stall_pre  <= pre_c;
            stall_post <= post_c;
         end
      end
   end

   assert_counter_step_R9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

   assert_pre_range_R9: assert property (@(posedge clk) disable iff (rst)
      (svc_hit && !gdma_busy) |=> (svc_valid && stall_pre >= 1 && stall_pre <= SW'(CNT_MOD)));

   assert_post_bound_R10: assert property (@(posedge clk) disable iff (rst)
      (svc_hit && !gdma_busy) |=> (stall_post <= $past(acc_len)));

   assert_busy_zero_R11: assert property (@(posedge clk) disable iff (rst)
      (svc_hit && gdma_busy) |=> (svc_valid && stall_pre == '0 && stall_post == '0));

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      svc_valid |=> !svc_valid || $past(svc_hit));
endmodule

// File: rtl/line_xfer_trigger.sv
module line_xfer_trigger
   import lxt_pkg::*;
#(
   parameter int unsigned N_CH        = 8,
   parameter int unsigned HW          = 11,
   parameter int unsigned VW          = 9,
   parameter int unsigned AW          = 16,
   parameter logic [15:0] ENABLE_ADDR = 16'h420C,
   parameter int unsigned TRIG_POS    = 1104,
   parameter int unsigned SAMPLE_LEAD = 4,
   parameter int unsigned CNT_MOD     = 8,
   parameter int unsigned ALEN_W      = 4,
   parameter int unsigned SW          = $clog2(CNT_MOD) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [HW-1:0]     h_count,
   input  logic [VW-1:0]     v_count,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [N_CH-1:0]   wr_data,
   input  logic [N_CH-1:0]   done_set,
   input  logic              gdma_busy,
   input  logic [ALEN_W-1:0] acc_len,
   input  logic              bus_edge,
   output logic              pending,
   output logic              mode,
   output logic              svc_valid,
   output logic              svc_mode,
   output logic [SW-1:0]     stall_pre,
   output logic [ALEN_W-1:0] stall_post,
   output logic [N_CH-1:0]   ch_active
);
   if (SAMPLE_LEAD > TRIG_POS) begin : g_bad_lead
      $error("SAMPLE_LEAD must not exceed TRIG_POS");
   end
   if (TRIG_POS >= (1 << HW)) begin : g_bad_pos
      $error("TRIG_POS does not fit in HW bits");
   end
   if ((CNT_MOD < 2) || ((CNT_MOD & (CNT_MOD - 1)) != 0)) begin : g_bad_mod
      $error("CNT_MOD must be a power of two of at least 2");
   end
   if (N_CH == 0) begin : g_bad_ch
      $error("N_CH must be at least 1");
   end

   logic [N_CH-1:0] en_q;
   logic [N_CH-1:0] completed_q;
   logic            line_start;

   lxt_enable_reg #(
      .N_CH(N_CH), .AW(AW), .ENABLE_ADDR(ENABLE_ADDR)
   ) u_enable (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .done_set(done_set), .line_start(line_start), .en_q(en_q),
      .completed_q(completed_q), .ch_active(ch_active)
   );

   lxt_line_trigger #(
      .N_CH(N_CH), .HW(HW), .VW(VW), .TRIG_POS(TRIG_POS), .SAMPLE_LEAD(SAMPLE_LEAD)
   ) u_trigger (
      .clk(clk), .rst(rst), .h_count(h_count), .v_count(v_count), .en_q(en_q),
      .completed_q(completed_q), .bus_edge(bus_edge), .line_start(line_start),
      .pending(pending), .mode(mode)
   );

   lxt_align #(
      .CNT_MOD(CNT_MOD), .ALEN_W(ALEN_W), .CW($clog2(CNT_MOD)), .SW(SW)
   ) u_align (
      .clk(clk), .rst(rst), .bus_edge(bus_edge), .pending(pending), .mode(mode),
      .gdma_busy(gdma_busy), .acc_len(acc_len), .svc_valid(svc_valid),
      .svc_mode(svc_mode), .stall_pre(stall_pre), .stall_post(stall_post)
   );
endmodule

// File: tb/line_xfer_trigger_bench.sv
module line_xfer_trigger_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [10:0] h_count = '0;
   logic [8:0]  v_count = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  done_set = '0;
   logic        gdma_busy = 1'b0;
   logic [3:0]  acc_len = '0;
   logic        bus_edge = 1'b0;
   logic        pending, mode, svc_valid, svc_mode;
   logic [3:0]  stall_pre, stall_post;
   logic [7:0]  ch_active;

   int total = 0;
   int bad = 0;
   int tb_cnt = 0;
   bit finished = 1'b0;
   logic [8:0] exp_q[$];

   always #4 clk = ~clk;

   line_xfer_trigger u_line_xfer_trigger (
      .clk(clk), .rst(rst), .h_count(h_count), .v_count(v_count), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .done_set(done_set), .gdma_busy(gdma_busy),
      .acc_len(acc_len), .bus_edge(bus_edge), .pending(pending), .mode(mode),
      .svc_valid(svc_valid), .svc_mode(svc_mode), .stall_pre(stall_pre),
      .stall_post(stall_post), .ch_active(ch_active)
   );

   always @(posedge clk) tb_cnt <= rst ? 0 : (tb_cnt + 1) % 8;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic new_line(input int v);
      v_count = 9'(v); h_count = '0;
      tick();
   endtask

   task automatic set_h(input int h);
      h_count = 11'(h);
      tick();
   endtask

   // Driver: pushes the expected service record, then strobes the edge.
   task automatic service(input bit busy, input int alen, input bit exp_mode);
      int pre;
      int post;
      pre  = busy ? 0 : 8 - tb_cnt;
      post = (busy || alen == 0) ? 0 : alen - (pre % alen);
      exp_q.push_back({exp_mode, 4'(pre), 4'(post)});
      gdma_busy = busy; acc_len = 4'(alen); bus_edge = 1'b1;
      tick();
      bus_edge = 1'b0; gdma_busy = 1'b0;
      chk(pending == 1'b0, "R8 pending cleared by service", int'(pending), 0);
   endtask

   // Monitor: pops and compares every service record.
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && svc_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5/R8 unexpected service record", 1, 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk(svc_mode == e[8], "R8 svc_mode", int'(svc_mode), int'(e[8]));
               chk(stall_pre == e[7:4], "R9/R11 stall_pre", int'(stall_pre), int'(e[7:4]));
               chk(stall_post == e[3:0], "R10/R11 stall_post", int'(stall_post), int'(e[3:0]));
            end
         end
      end
   end

   task automatic finish_run();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 1, 0);
         finish_run();
      end
   end

   initial begin
      tick(); tick(); tick();
      rst = 1'b0;
      tick();
      // R12 reset state
      chk(pending == 1'b0, "R12 pending after reset", int'(pending), 0);
      chk(mode == 1'b0, "R12 mode after reset", int'(mode), 0);
      chk(svc_valid == 1'b0, "R12 svc_valid after reset", int'(svc_valid), 0);
      chk(ch_active == 8'h00, "R12 ch_active after reset", int'(ch_active), 0);

      // R1 enable write and ignored address
      write_reg(16'h420C, 8'h05);
      chk(ch_active == 8'h05, "R1 enable load", int'(ch_active), 5);
      write_reg(16'h4200, 8'hFF);
      chk(ch_active == 8'h05, "R1 other address ignored", int'(ch_active), 5);

      // R2 completed flag and line clear
      new_line(1);
      done_set = 8'h01;
      tick();
      done_set = 8'h00;
      chk(ch_active == 8'h04, "R2 completed masks channel", int'(ch_active), 4);
      new_line(2);
      chk(ch_active == 8'h05, "R2 new line clears completed", int'(ch_active), 5);

      // R3/R4 trigger on line 2
      set_h(1102);
      chk(pending == 1'b0, "R3 no trigger before 1104", int'(pending), 0);
      set_h(1104);
      chk(pending == 1'b1, "R4 pending at trigger", int'(pending), 1);
      chk(mode == 1'b1, "R4 run mode", int'(mode), 1);
      set_h(1106);
      service(1'b0, 6, 1'b1);
      set_h(1108); set_h(1200);
      chk(pending == 1'b0, "R3 single trigger per line", int'(pending), 0);

      // R11 busy service on line 3
      new_line(3); set_h(1104);
      chk(pending == 1'b1, "R3 retrigger on next line", int'(pending), 1);
      service(1'b1, 6, 1'b1);

      // R10 access length variants, R9 different counter phases
      new_line(4); set_h(1104); tick();
      service(1'b0, 8, 1'b1);
      new_line(5); set_h(1106);
      service(1'b0, 0, 1'b1);
      new_line(6); set_h(1110); tick(); tick();
      service(1'b0, 12, 1'b1);

      // R5 no active channel at trigger
      write_reg(16'h420C, 8'h01);
      new_line(7);
      done_set = 8'h01;
      tick();
      done_set = 8'h00;
      set_h(1104); tick();
      chk(pending == 1'b0, "R5 no request when no channel active", int'(pending), 0);

      // R6 write inside the capture window
      write_reg(16'h420C, 8'h00);
      new_line(8);
      set_h(1100);
      wr_en = 1'b1; wr_addr = 16'h420C; wr_data = 8'h02; h_count = 11'd1102;
      tick();
      wr_en = 1'b0;
      set_h(1104);
      chk(pending == 1'b0, "R6 late write ignored this line", int'(pending), 0);
      chk(ch_active == 8'h02, "R6 late write stored", int'(ch_active), 2);
      new_line(9); set_h(1104);
      chk(pending == 1'b1, "R6 late write used next line", int'(pending), 1);
      tick();
      service(1'b0, 12, 1'b1);

      // R7 setup request at frame start
      new_line(0);
      chk(pending == 1'b1, "R7 setup request pending", int'(pending), 1);
      chk(mode == 1'b0, "R7 setup mode", int'(mode), 0);
      service(1'b0, 6, 1'b0);

      tick(); tick();
      chk(exp_q.size() == 0, "R8 all service records seen", exp_q.size(), 0);
      finish_run();
   end
endmodule